// File: doc/BRIEF.md
# Sensor Channel Sequencer Controller

This block drives an eight-channel sensing converter through a chosen order of channel numbers. Software writes a command word over a simple register bus. The word selects a sweep pattern, either a single pass or repeated passes, an output flavour (raw or calibrated), and a run flag. While the run flag is set, the block issues one conversion at a time. Each conversion is a one-cycle start pulse that carries a 3-bit channel number. The block then waits for the converter's done strobe and stores the returned 12-bit value in that channel's result register.

There are four sweep patterns: channels 2 up to 7, channels 0 up to 7, channels 0 and 1, or the single channel named in the command. A single pass clears the run flag by itself when it ends. When software writes the run flag to zero during a run, the conversion in flight is allowed to complete, and the hardware then clears the flag. The converter's done strobe is a valid-only return path with no back-pressure: the block can always accept it while a conversion is outstanding, and it ignores the strobe at any other time. The register bus reads combinationally and writes in one cycle, with no wait states.

Top module: `sensor_seq_ctrl`

## Requirements
- R1: After reset, the command word at byte offset 0x00 reads 0, all eight result words read 0, the status word reads 0, and conv_start is low.
- R2: When RUN is clear, a write to offset 0x00 stores the following fields, which read back in place: RUN at bit 0, MODE at bits 2:1, the selected channel at bits 6:4, the sweep select at bits 9:8, the polarity pair at bits 11:10, and the calibrated-output flag at bit 12. Bits 3, 7 and 31:13 read 0. The polarity bits do not change behaviour.
- R3: Sweep select 00 converts channels 2, 3, 4, 5, 6, 7 in that order.
- R4: Sweep select 01 converts channels 0 through 7 in rising order, and sweep select 10 converts channel 0 and then channel 1.
- R5: Sweep select 11 converts only the channel held in bits 6:4.
- R6: MODE 00 makes exactly one pass of the selected sweep, and the hardware then clears RUN.
- R7: MODE 01 repeats the sweep without end. After software writes RUN to 0, at most one further conversion (the one in flight) completes, RUN then reads 0, and no more start pulses follow.
- R8: A run started with MODE 10 or 11 clears RUN on the next clock edge and issues no start pulse.
- R9: While RUN is set, a write to offset 0x00 changes no field. A write with bit 0 low only requests a stop; its other bits are ignored.
- R10: conv_start is high for exactly one cycle per conversion. The status word at offset 0x24 reads 1 in bit 0 from the start pulse until the done strobe is taken. The result for channel c is stored at offset 0x04 + 4*c.
- R11: Each stored result is conv_cal when bit 12 is set and conv_raw when it is clear.
- R12: A done strobe that arrives while no conversion is outstanding changes no result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address for register reads and writes |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel number for the current conversion |
| conv_done | input | 1 | Converter result valid strobe |
| conv_raw | input | 12 | Uncalibrated converter value |
| conv_cal | input | 12 | Calibrated converter value |

## Verification
The checker assumes that the converter raises conv_done for exactly one cycle for each start pulse and never before that pulse. It also assumes that software never changes the command fields while a run is in progress, other than by requesting a stop. The bench's converter model honours the first assumption with a set latency per run, plus one deliberately stray strobe that is injected only while the block is idle. The bench's write sequences deliberately break the second assumption, and those writes are then checked at the ports to confirm they are ignored.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int CH_W = 3;

  typedef enum logic [1:0] {
    SWEEP_HIGH6  = 2'b00,
    SWEEP_ALL8   = 2'b01,
    SWEEP_LOW2   = 2'b10,
    SWEEP_SINGLE = 2'b11
  } sweep_e;

  typedef struct packed {
    logic            cal;
    logic [1:0]      pol;
    sweep_e          sweep;
    logic [CH_W-1:0] chsel;
    logic [1:0]      mode;
    logic            run;
  } cmd_t;

  function automatic logic [CH_W-1:0] sweep_first(sweep_e s, logic [CH_W-1:0] sel);
    case (s)
      SWEEP_HIGH6:  sweep_first = CH_W'(2);
      SWEEP_SINGLE: sweep_first = sel;
      default:      sweep_first = '0;
    endcase
  endfunction

  function automatic logic [CH_W-1:0] sweep_last(sweep_e s, logic [CH_W-1:0] sel);
    case (s)
      SWEEP_LOW2:   sweep_last = CH_W'(1);
      SWEEP_SINGLE: sweep_last = sel;
      default:      sweep_last = '1;
    endcase
  endfunction
endpackage

// File: rtl/ssc_cmd_reg.sv
module ssc_cmd_reg
  import ssc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [12:0] wfield,
  input  logic        run_clr,
  output cmd_t        cmd,
  output logic        stop_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd      <= '0;
      stop_req <= 1'b0;
    end else if (run_clr) begin
      cmd.run  <= 1'b0;
      stop_req <= 1'b0;
    end else if (wr_en) begin
      if (!cmd.run) begin
        cmd.run   <= wfield[0];
        cmd.mode  <= wfield[2:1];
        cmd.chsel <= wfield[6:4];
        cmd.sweep <= sweep_e'(wfield[9:8]);
        cmd.pol   <= wfield[11:10];
        cmd.cal   <= wfield[12];
      end else if (!wfield[0]) begin
        stop_req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssc_sequencer.sv
module ssc_sequencer
  import ssc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  cmd_t            cmd,
  input  logic            stop_req,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan,
  output logic            run_clr,
  output logic            busy,
  output logic            store_en
);
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} state_e;

  state_e          state_q, state_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic [CH_W-1:0] first_ch, last_ch;
  logic            mode_bad, one_pass;

  assign first_ch = sweep_first(cmd.sweep, cmd.chsel);
  assign last_ch  = sweep_last(cmd.sweep, cmd.chsel);
  assign mode_bad = cmd.mode[1];
  assign one_pass = (cmd.mode == 2'b00);

  always_comb begin
    state_d  = state_q;
    chan_d   = chan_q;
    run_clr  = 1'b0;
    store_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd.run) begin
          if (mode_bad) begin
            run_clr = 1'b1;
          end else begin
            chan_d  = first_ch;
            state_d = ST_START;
          end
        end
      end
      ST_START: state_d = ST_WAIT;
      ST_WAIT: begin
        if (conv_done) begin
          store_en = 1'b1;
          if (stop_req || (chan_q == last_ch && one_pass)) begin
            run_clr = 1'b1;
            state_d = ST_IDLE;
          end else if (chan_q == last_ch) begin
            chan_d  = first_ch;
            state_d = ST_START;
          end else begin
            chan_d  = chan_q + 1'b1;
            state_d = ST_START;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
    end
  end

  assign conv_start = (state_q == ST_START);
  assign conv_chan  = chan_q;
  assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/ssc_results.sv
module ssc_results #(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 8,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_en,
  input  logic [IDX_W-1:0]  store_idx,
  input  logic [DATA_W-1:0] store_val,
  output logic [DATA_W-1:0] res [NUM_CH]
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        res[g] <= '0;
      else if (store_en && store_idx == IDX_W'(g))
        res[g] <= store_val;
    end
  end
endmodule

// File: rtl/sensor_seq_ctrl.sv
module sensor_seq_ctrl
  import ssc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int AW     = 6,
  localparam int NUM_CH   = 1 << CH_W,
  localparam int STAT_IDX = NUM_CH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_raw,
  input  logic [DATA_W-1:0] conv_cal
);
  cmd_t              cmd;
  logic              stop_req, run_clr, busy, store_en, cmd_wr;
  logic [DATA_W-1:0] res [NUM_CH];
  logic [DATA_W-1:0] store_val;
  logic [AW-3:0]     word_idx;
  logic [31:0]       cmd_word;
  logic              unused_wbits;

  assign cmd_wr       = bus_we && (bus_addr == '0);
  assign unused_wbits = ^{bus_wdata[31:13], bus_wdata[7], bus_wdata[3]};
  assign store_val    = cmd.cal ? conv_cal : conv_raw;

  ssc_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr), .wfield(bus_wdata[12:0]),
    .run_clr(run_clr), .cmd(cmd), .stop_req(stop_req)
  );

  ssc_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .stop_req(stop_req),
    .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
    .run_clr(run_clr), .busy(busy), .store_en(store_en)
  );

  ssc_results #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_res (
    .clk(clk), .rst_n(rst_n), .store_en(store_en), .store_idx(conv_chan),
    .store_val(store_val), .res(res)
  );

  assign cmd_word = {19'b0, cmd.cal, cmd.pol, cmd.sweep, 1'b0, cmd.chsel,
                     1'b0, cmd.mode, cmd.run};
  assign word_idx = bus_addr[AW-1:2];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (word_idx == '0)
        bus_rdata = cmd_word;
      else if (word_idx == (AW-2)'(STAT_IDX))
        bus_rdata = {31'b0, busy};
      else if (int'(word_idx) <= NUM_CH)
        bus_rdata = 32'(res[CH_W'(word_idx - 1'b1)]);
    end
  end
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker
  import ssc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_chan,
  input logic            busy,
  input logic            run,
  input logic [1:0]      mode,
  input logic [1:0]      sweep,
  input logic [CH_W-1:0] chsel,
  input logic            stop_req
);
  assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  assert_start_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> run);
  assert_high6_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && sweep == 2'b00) |-> conv_chan >= CH_W'(2));
  assert_low2_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && sweep == 2'b10) |-> conv_chan <= CH_W'(1));
  assert_single_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && sweep == 2'b11) |-> conv_chan == chsel);
  assert_reserved_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode[1] && !busy) |=> !run);
  assert_fields_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(mode) && $stable(sweep) && $stable(chsel)));
  assert_stop_with_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> run);
endmodule

bind sensor_seq_ctrl ssc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
  .busy(busy), .run(cmd.run), .mode(cmd.mode), .sweep(cmd.sweep),
  .chsel(cmd.chsel), .stop_req(stop_req)
);

// File: tb/sensor_seq_ctrl_tb.sv
module sensor_seq_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        conv_start, conv_done = 0;
  logic [2:0]  conv_chan;
  logic [11:0] conv_raw = '0, conv_cal = '0;

  int errors = 0, checks = 0, cycles = 0;
  int log_ch [0:255];
  int log_n = 0, lat = 0, stamp = 0;
  logic cal_now = 0, spur = 0;
  logic [11:0] exp_res [0:7];

  always #2.5 clk = ~clk;

  sensor_seq_ctrl u_dut (.*);

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
        finish_run();
      end
    end
  end

  // Converter model: responds lat cycles after a start, one-cycle done.
  initial begin
    bit pend = 0; int cnt = 0; int ch = 0;
    logic [11:0] r;
    forever begin
      @(negedge clk);
      conv_done = 0;
      if (spur) begin
        conv_done = 1; conv_raw = 12'hABC; conv_cal = 12'h123; spur = 0;
      end else if (pend) begin
        if (cnt == 0) begin
          stamp++;
          r = 12'((stamp * 29 + ch * 3 + 1) & 12'hFFF);
          conv_raw = r; conv_cal = r ^ 12'h5A5; conv_done = 1;
          exp_res[ch] = cal_now ? (r ^ 12'h5A5) : r;
          pend = 0;
        end else cnt--;
      end
      if (conv_start) begin
        if (log_n < 256) log_ch[log_n] = int'(conv_chan);
        log_n++; ch = int'(conv_chan); pend = 1; cnt = lat;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v; int n = 0;
    do begin rd(6'h00, v); n++; end while (v[0] && n < 3000);
    chk(!v[0], req, int'(v[0]), 0);
  endtask

  function automatic int sweep_len(int s);
    case (s) 0: return 6; 1: return 8; 2: return 2; default: return 1; endcase
  endfunction

  function automatic int sweep_ch(int s, int sel, int i);
    case (s) 0: return 2 + i; 3: return sel; default: return i; endcase
  endfunction

  task automatic check_results(input string req);
    logic [31:0] v;
    for (int c = 0; c < 8; c++) begin
      rd(6'(4 + 4 * c), v);
      chk(v == 32'(exp_res[c]), req, int'(v), int'(exp_res[c]));
    end
  endtask

  initial begin
    logic [31:0] v; int n_at; bit ok;
    for (int c = 0; c < 8; c++) exp_res[c] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(6'h00, v); chk(v == 0, "R1 cmd", int'(v), 0);
    rd(6'h24, v); chk(v == 0, "R1 status", int'(v), 0);
    chk(!conv_start, "R1 start", int'(conv_start), 0);
    check_results("R1 results");
    rst_n = 1;
    rd(6'h00, v); chk(v == 0, "R1 cmd after release", int'(v), 0);

    // R2 layout and reserved bits
    wr(6'h00, 32'hFFFF_FFFE);
    rd(6'h00, v); chk(v == 32'h1F76, "R2 readback", int'(v), 32'h1F76);
    wr(6'h00, 32'h0000_0000);

    // R3 R4 R5 R6 R11: one pass of each sweep, raw and calibrated, polarity varied
    for (int s = 0; s < 4; s++) begin
      for (int cal = 0; cal < 2; cal++) begin
        logic [31:0] cw;
        cw = 32'(1 | (5 << 4) | (s << 8) | (cal << 12) | (((s + cal) & 3) << 10));
        lat = s + cal; log_n = 0; cal_now = cal[0];
        wr(6'h00, cw);
        wait_idle("R6 run cleared after pass");
        repeat (lat + 3) @(negedge clk);
        chk(log_n == sweep_len(s), "R6 pass length", log_n, sweep_len(s));
        ok = 1;
        for (int i = 0; i < sweep_len(s) && i < log_n; i++)
          if (log_ch[i] != sweep_ch(s, 5, i)) ok = 0;
        chk(ok, s == 0 ? "R3 order" : (s == 3 ? "R5 order" : "R4 order"), log_ch[0], sweep_ch(s, 5, 0));
        rd(6'h00, v); chk(v == (cw & ~32'h1), "R2 fields kept", int'(v), int'(cw & ~32'h1));
        check_results("R11 stored value");
      end
    end

    // R7 continuous with stop
    lat = 2; log_n = 0; cal_now = 0;
    wr(6'h00, 32'h0000_0203);
    begin int n = 0; while (log_n < 7 && n < 2000) begin @(negedge clk); n++; end end
    n_at = log_n;
    wr(6'h00, 32'h0);
    wait_idle("R7 run cleared after stop");
    chk(log_n - n_at <= 1, "R7 at most one more", log_n - n_at, 1);
    ok = 1;
    for (int i = 0; i < log_n; i++) if (log_ch[i] != (i & 1)) ok = 0;
    chk(ok, "R7 repeated pair", log_n, n_at);
    n_at = log_n; repeat (20) @(negedge clk);
    chk(log_n == n_at, "R7 no start after clear", log_n, n_at);
    check_results("R7 results");

    // R8 reserved modes
    for (int m = 2; m < 4; m++) begin
      log_n = 0;
      wr(6'h00, 32'(1 | (m << 1) | (1 << 8)));
      repeat (4) @(negedge clk);
      rd(6'h00, v); chk(v[0] == 0, "R8 run cleared", int'(v[0]), 0);
      chk(log_n == 0, "R8 no start", log_n, 0);
    end

    // R9 writes while running are ignored; stop ignores other bits
    lat = 30; log_n = 0; cal_now = 0;
    wr(6'h00, 32'h0000_0101);
    repeat (3) @(negedge clk);
    wr(6'h00, 32'h0000_1371);
    rd(6'h00, v); chk(v == 32'h101, "R9 write ignored", int'(v), 32'h101);
    // R10 busy during conversion
    rd(6'h24, v); chk(v == 1, "R10 busy high", int'(v), 1);
    wait_idle("R9 pass completes");
    chk(log_n == 8, "R9 sweep unchanged", log_n, 8);
    rd(6'h24, v); chk(v == 0, "R10 busy low", int'(v), 0);
    log_n = 0;
    wr(6'h00, 32'h0000_0101);
    repeat (3) @(negedge clk);
    wr(6'h00, 32'h0000_1F76);
    wait_idle("R9 stop honoured");
    rd(6'h00, v); chk(v == 32'h100, "R9 stop fields ignored", int'(v), 32'h100);
    chk(log_n == 1, "R9 stop after in-flight", log_n, 1);
    check_results("R10 result slots");

    // R12 stray done while idle
    repeat (40) @(negedge clk);
    spur = 1;
    repeat (4) @(negedge clk);
    check_results("R12 stray done ignored");

    finish_run();
  end
endmodule